// File: doc/BRIEF.md
# Double-Buffered Subcode Q Capture

This block sits between a disc decoder and a control host. The decoder delivers the 80-bit subcode Q payload one bit per strobe. The block stores the bits in whichever of two 80-bit banks is currently the write bank. When the decoder signals that a block is complete, the banks trade roles. The finished block becomes readable while the next one fills the other bank, so the decoder and the host never touch the same storage.

A fresh block opens a read window, shown by an active-low ready flag. The window stays open for a parameterised number of frame ticks, and it is never opened or kept open while the pickup is in a tracking search. During the window the host issues a read command and then reads the block as twenty 4-bit words. It supplies rising edges on its read clock, and those edges must be spaced by a minimum number of system clocks.

A block that completes during a read is held back. The bank swap waits until the read finishes or is aborted.

Top module: `qsub_dbuf`

## Requirements
- R1: After reset, `rd_rdy_n` is 1 and `rd_bus` is 0.
- R2: The bit received at position i of a block (0 = first) is stored at index i. Word k (k = 0..19) holds bits 4k..4k+3, with bit 4k on `rd_bus[3]` and bit 4k+3 on `rd_bus[0]`.
- R3: A `blk_done` pulse while no read is active swaps the banks. A read then returns the block just completed, while later bits fill the other bank from position 0.
- R4: `rd_rdy_n` goes low in the cycle after a swap made while `track_busy` is 0. It stays low through WIN_FRAMES-1 `frame_tick` pulses and returns high on the WIN_FRAMES-th pulse.
- R5: `track_busy` high forces `rd_rdy_n` high from the next cycle and closes the window. A swap made while `track_busy` is high opens no window.
- R6: `rd_cmd` is accepted only while `rd_rdy_n` is low and `track_busy` is 0. On acceptance, `rd_rdy_n` is high and `rd_bus` is 0 in the next cycle, and a read of word 0 onward begins.
- R7: During a read, each accepted rising edge of `rd_clk` puts the next word on `rd_bus` one cycle later. The 20th edge shows word 19 and ends the read.
- R8: During a read, a rising edge of `rd_clk` that comes fewer than MIN_GAP cycles after the previous accepted edge, or after the accepted command, is ignored and `rd_bus` holds its value.
- R9: A rising edge of `rd_clk` while no read is active (including a 21st edge) drives `rd_bus` to 0.
- R10: A `blk_done` pulse during a read defers the swap until the cycle after the read ends. Bits strobed while the swap is pending are dropped.
- R11: `track_busy` during a read aborts it. The pending swap is then performed, and because the busy flag is still high no window opens.
- R12: `rd_cmd` while `rd_rdy_n` is high starts no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| q_bit | input | 1 | Serial Q payload bit |
| q_stb | input | 1 | Takes `q_bit` into the write bank |
| blk_done | input | 1 | Pulse: the current Q block is complete |
| frame_tick | input | 1 | Pulse once per frame; times the read window |
| track_busy | input | 1 | Tracking search in progress |
| rd_cmd | input | 1 | Host read command pulse |
| rd_clk | input | 1 | Host read clock, level sampled on `clk` |
| rd_bus | output | 4 | Current read word |
| rd_rdy_n | output | 1 | Active-low read window flag |

## Verification
`rd_rdy_n` reacts one cycle after the edge that samples `blk_done`, `rd_cmd`, `track_busy` or the closing `frame_tick`. A deferred swap adds one more cycle after the read ends. `rd_bus` changes one cycle after the edge at which `rd_clk` is first seen high. The bench drives inputs on the falling clock edge and samples on the next falling edge, which is exactly one register stage later. Edge spacing is produced by idle cycles counted against MIN_GAP.

// File: rtl/qsub_pkg.sv
package qsub_pkg;
   typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_e;

   function automatic bank_e other_bank(input bank_e b);
      return (b == BANK_A) ? BANK_B : BANK_A;
   endfunction
endpackage

// File: rtl/qsub_capture.sv
module qsub_capture
   import qsub_pkg::*;
#(
   parameter int Q_BITS = 80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              q_bit,
   input  logic              q_stb,
   input  logic              hold,
   input  logic              swap,
   output logic [Q_BITS-1:0] rd_bank,
   output bank_e             wsel
);
   localparam int CW = $clog2(Q_BITS + 1);

   logic [Q_BITS-1:0] bank_q [2];
   logic [CW-1:0]     cnt;
   logic              wr_ok;

   assign wr_ok = q_stb && !hold && !swap && (cnt < CW'(Q_BITS));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wsel <= BANK_A;
         cnt  <= '0;
      end else if (swap) begin
         wsel <= other_bank(wsel);
         cnt  <= '0;
      end else if (wr_ok) begin
         cnt  <= cnt + 1'b1;
      end
   end

   for (genvar g = 0; g < 2; g++) begin : g_bank
      always_ff @(posedge clk) begin
         if (!rst_n)
            bank_q[g] <= '0;
         else if (wr_ok && (wsel == bank_e'(g)))
            bank_q[g][cnt] <= q_bit;
      end
   end

   assign rd_bank = (wsel == BANK_A) ? bank_q[1] : bank_q[0];

   assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(Q_BITS));
endmodule

// File: rtl/qsub_window.sv
module qsub_window #(
   parameter int WIN_FRAMES = 80
) (
   input  logic clk,
   input  logic rst_n,
   input  logic open_go,
   input  logic close_go,
   input  logic frame_tick,
   output logic win
);
   localparam int FW = $clog2(WIN_FRAMES + 1);

   logic [FW-1:0] fcnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win  <= 1'b0;
         fcnt <= '0;
      end else if (close_go) begin
         win  <= 1'b0;
      end else if (open_go) begin
         win  <= 1'b1;
         fcnt <= '0;
      end else if (win && frame_tick) begin
         if (fcnt == FW'(WIN_FRAMES - 1))
            win <= 1'b0;
         else
            fcnt <= fcnt + 1'b1;
      end
   end

   assert_win_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      win |-> (fcnt < FW'(WIN_FRAMES)));
endmodule

// File: rtl/qsub_reader.sv
module qsub_reader #(
   parameter int Q_BITS  = 80,
   parameter int NIB     = 4,
   parameter int MIN_GAP = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              abort,
   input  logic              rclk,
   input  logic [Q_BITS-1:0] rd_bank,
   output logic [NIB-1:0]    bus,
   output logic              active
);
   localparam int WORDS = Q_BITS / NIB;
   localparam int IW    = (WORDS > 1) ? $clog2(WORDS) : 1;
   localparam int BW    = $clog2(Q_BITS);

   logic [IW-1:0]  idx;
   logic           rclk_q;
   logic           rise;
   logic           gap_ok;
   logic           take;
   logic [NIB-1:0] nib_sel;

   assign rise = rclk & ~rclk_q;
   assign take = start | (rise & active & gap_ok);

   always_comb begin
      for (int j = 0; j < NIB; j++)
         nib_sel[NIB-1-j] = rd_bank[BW'(idx) * BW'(NIB) + BW'(j)];
   end

   if (MIN_GAP > 0) begin : g_gap
      localparam int GW = $clog2(MIN_GAP + 1);
      logic [GW-1:0] gap_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            gap_q <= GW'(MIN_GAP);
         else if (take)
            gap_q <= '0;
         else if (gap_q < GW'(MIN_GAP))
            gap_q <= gap_q + 1'b1;
      end
      assign gap_ok = (gap_q == GW'(MIN_GAP));
   end else begin : g_nogap
      assign gap_ok = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rclk_q <= 1'b0;
         active <= 1'b0;
         idx    <= '0;
         bus    <= '0;
      end else begin
         rclk_q <= rclk;
         if (start) begin
            active <= 1'b1;
            idx    <= '0;
            bus    <= '0;
         end else if (abort && active) begin
            active <= 1'b0;
         end else if (rise) begin
            if (!active) begin
               bus <= '0;
            end else if (gap_ok) begin
               bus <= nib_sel;
               if (idx == IW'(WORDS - 1))
                  active <= 1'b0;
               else
                  idx <= idx + 1'b1;
            end
         end
      end
   end

   assert_idx_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (idx < IW'(WORDS)));

   assert_early_edge_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (active && rise && !gap_ok && !start) |=> $stable(bus));
endmodule

// File: rtl/qsub_dbuf.sv
module qsub_dbuf
   import qsub_pkg::*;
#(
   parameter int Q_BITS     = 80,
   parameter int NIB        = 4,
   parameter int WIN_FRAMES = 80,
   parameter int MIN_GAP    = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           q_bit,
   input  logic           q_stb,
   input  logic           blk_done,
   input  logic           frame_tick,
   input  logic           track_busy,
   input  logic           rd_cmd,
   input  logic           rd_clk,
   output logic [NIB-1:0] rd_bus,
   output logic           rd_rdy_n
);
   if ((Q_BITS % NIB) != 0 || Q_BITS < NIB) begin : g_bad_width
      $error("Q_BITS must be a positive multiple of NIB");
   end
   if (WIN_FRAMES < 1 || MIN_GAP < 0) begin : g_bad_timing
      $error("WIN_FRAMES must be at least 1 and MIN_GAP not negative");
   end

   logic [Q_BITS-1:0] rd_bank;
   bank_e             wsel;
   logic              win;
   logic              rd_active;
   logic              pend_q;
   logic              swap_go;
   logic              cmd_ok;

   assign swap_go  = !rd_active && (blk_done || pend_q);
   assign cmd_ok   = rd_cmd && win && !track_busy;
   assign rd_rdy_n = ~win;

   always_ff @(posedge clk) begin
      if (!rst_n)
         pend_q <= 1'b0;
      else if (swap_go)
         pend_q <= 1'b0;
      else if (blk_done && rd_active)
         pend_q <= 1'b1;
   end

   qsub_capture #(.Q_BITS(Q_BITS)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .q_bit   (q_bit),
      .q_stb   (q_stb),
      .hold    (pend_q),
      .swap    (swap_go),
      .rd_bank (rd_bank),
      .wsel    (wsel)
   );

   qsub_window #(.WIN_FRAMES(WIN_FRAMES)) u_win (
      .clk        (clk),
      .rst_n      (rst_n),
      .open_go    (swap_go && !track_busy),
      .close_go   (track_busy || cmd_ok),
      .frame_tick (frame_tick),
      .win        (win)
   );

   qsub_reader #(.Q_BITS(Q_BITS), .NIB(NIB), .MIN_GAP(MIN_GAP)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (cmd_ok),
      .abort   (track_busy),
      .rclk    (rd_clk),
      .rd_bank (rd_bank),
      .bus     (rd_bus),
      .active  (rd_active)
   );

   assert_busy_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      track_busy |=> rd_rdy_n);

   assert_window_read_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({win, rd_active}));

   assert_no_swap_in_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_active && $past(rd_active)) |-> $stable(wsel));
endmodule

// File: tb/tb_qsub_dbuf.sv
module tb_qsub_dbuf;
   localparam int Q   = 80;
   localparam int GAP = 8;
   localparam int WIN = 80;

   localparam logic [Q-1:0] VEC [4] = '{
      80'h123456789ABCDEF02468,
      80'hFEDCBA9876543210ACE1,
      80'h5A5A5A5AA5A5A5A50F0F,
      80'h0000FFFF1111EEEE8421
   };
   localparam logic [Q-1:0] BLK_A = 80'hC3C33C3C969669697E7E;
   localparam logic [Q-1:0] BLK_B = 80'h8BADF00D1234CAFE5EED;
   localparam logic [Q-1:0] BLK_C = 80'h222244446666888AAAA2;
   localparam logic [Q-1:0] BLK_E = 80'h77771111BBBBDDDD3333;

   logic       clk = 1'b0;
   logic       rst_n, q_bit, q_stb, blk_done, frame_tick, track_busy, rd_cmd, rd_clk;
   logic [3:0] rd_bus;
   logic       rd_rdy_n;
   int         checks = 0;
   int         errors = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   qsub_dbuf #(.Q_BITS(Q), .NIB(4), .WIN_FRAMES(WIN), .MIN_GAP(GAP)) dut (
      .clk(clk), .rst_n(rst_n), .q_bit(q_bit), .q_stb(q_stb), .blk_done(blk_done),
      .frame_tick(frame_tick), .track_busy(track_busy), .rd_cmd(rd_cmd),
      .rd_clk(rd_clk), .rd_bus(rd_bus), .rd_rdy_n(rd_rdy_n)
   );

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send_bits(input logic [Q-1:0] v, input int n);
      for (int i = 0; i < n; i++) begin
         q_bit = v[Q-1-i];
         q_stb = 1'b1;
         tick();
      end
      q_stb = 1'b0;
   endtask

   task automatic pulse_done();
      blk_done = 1'b1; tick(); blk_done = 1'b0;
   endtask

   task automatic do_cmd();
      rd_cmd = 1'b1; tick(); rd_cmd = 1'b0;
   endtask

   task automatic rclk_edge();
      repeat (GAP) tick();
      rd_clk = 1'b1; tick(); rd_clk = 1'b0;
   endtask

   task automatic read_words(input logic [Q-1:0] v, input int k0, input int k1, input string tag);
      for (int k = k0; k <= k1; k++) begin
         rclk_edge();
         chk(tag, 32'(rd_bus), 32'(v[Q-1-4*k -: 4]));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; q_bit = 1'b0; q_stb = 1'b0; blk_done = 1'b0; frame_tick = 1'b0;
      track_busy = 1'b0; rd_cmd = 1'b0; rd_clk = 1'b0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      chk("R1 rdy_n after reset", 32'(rd_rdy_n), 1);
      chk("R1 bus after reset", 32'(rd_bus), 0);

      // table walk: R2 word order, R3 swap, R6 command, R7 twenty words, R9 21st edge
      for (int t = 0; t < 4; t++) begin
         send_bits(VEC[t], Q);
         pulse_done();
         chk("R3 window opens after swap", 32'(rd_rdy_n), 0);
         do_cmd();
         chk("R6 rdy_n high after cmd", 32'(rd_rdy_n), 1);
         chk("R6 bus zero after cmd", 32'(rd_bus), 0);
         read_words(VEC[t], 0, 19, "R2 R7 word");
         rclk_edge();
         chk("R9 21st edge drives zero", 32'(rd_bus), 0);
      end

      // R4 window length
      send_bits(BLK_A, Q);
      pulse_done();
      chk("R4 window open", 32'(rd_rdy_n), 0);
      for (int f = 0; f < WIN - 1; f++) begin
         frame_tick = 1'b1; tick(); frame_tick = 1'b0;
      end
      chk("R4 still open before last frame", 32'(rd_rdy_n), 0);
      frame_tick = 1'b1; tick(); frame_tick = 1'b0;
      chk("R4 closed after last frame", 32'(rd_rdy_n), 1);

      // R12 command outside window
      do_cmd();
      chk("R12 rdy_n stays high", 32'(rd_rdy_n), 1);
      rclk_edge();
      chk("R12 no read started", 32'(rd_bus), 0);

      // R5 tracking search
      send_bits(BLK_B, Q);
      pulse_done();
      chk("R5 window open", 32'(rd_rdy_n), 0);
      track_busy = 1'b1; tick();
      chk("R5 busy closes window", 32'(rd_rdy_n), 1);
      pulse_done();
      tick();
      track_busy = 1'b0; tick();
      chk("R5 swap under busy opens nothing", 32'(rd_rdy_n), 1);

      // R10 deferred swap during read
      send_bits(BLK_A, Q);
      pulse_done();
      chk("R10 window for A", 32'(rd_rdy_n), 0);
      do_cmd();
      read_words(BLK_A, 0, 4, "R10 A head");
      send_bits(BLK_B, Q);
      pulse_done();
      send_bits(BLK_C, 8);
      chk("R10 no window during read", 32'(rd_rdy_n), 1);
      read_words(BLK_A, 5, 19, "R10 A tail");
      tick();
      chk("R10 window after deferred swap", 32'(rd_rdy_n), 0);
      do_cmd();
      read_words(BLK_B, 0, 19, "R10 B intact");

      // R8 early edge, then R11 abort
      send_bits(BLK_E, Q);
      pulse_done();
      do_cmd();
      read_words(BLK_E, 0, 0, "R8 first word");
      tick(); tick();
      rd_clk = 1'b1; tick(); rd_clk = 1'b0;
      chk("R8 early edge ignored", 32'(rd_bus), 32'(BLK_E[Q-1 -: 4]));
      read_words(BLK_E, 1, 1, "R8 next word");
      send_bits(BLK_C, Q);
      pulse_done();
      track_busy = 1'b1;
      repeat (3) tick();
      track_busy = 1'b0; tick();
      chk("R11 no window after abort", 32'(rd_rdy_n), 1);
      rclk_edge();
      chk("R11 read aborted", 32'(rd_bus), 0);
      pulse_done();
      chk("R11 window after next swap", 32'(rd_rdy_n), 0);
      do_cmd();
      read_words(BLK_E, 0, 0, "R11 swap done at abort");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule